// File: doc/BRIEF.md
# Power-Delivery Packet Receive Deframer

This block sits between a frequency-shift-keyed demodulator and the protocol layer of a power-negotiation link carried over the supply wire. Each recovered line bit arrives with a one-cycle strobe. While an external activity detector reports traffic, the block scans the bit stream. It skips the alternating preamble and locks symbol alignment on the start-of-packet code. It then turns 5-bit line codes back into nibbles and bytes until the end-of-packet code appears.

Received bytes stay in a local buffer until the whole-packet CRC-32 verdict is known. A packet that passes is replayed to the protocol layer as a burst of payload bytes, without the four check bytes. A packet that fails, or that is cut short, produces only a bad-status pulse. Its bytes are dropped, so the protocol layer never sees a corrupted byte. When the line goes quiet, the block holds its search window cleared and ignores all bits.

Top module: `pd_rx_deframer`

## Requirements
- R1: While `sq_active` is low, bits are ignored. If `sq_active` falls while a start sequence is being checked, the block returns to preamble search silently. If it falls while data symbols are being received, the block aborts the packet with a bad-status pulse (`pkt_done`=1, `pkt_good`=0).
- R2: Alignment comes from a sliding 5-bit window. A new bit enters at the LSB, so the first-received bit of a symbol is its MSB. The window must equal 5'b11000 to start a packet. An alternating 1010... preamble never causes alignment.
- R3: The start sequence is four symbols, each nominally 11000. The first must match exactly. The packet is accepted when at least 3 of the 4 match. With 2 or fewer matches the block goes back to preamble search.
- R4: Data codes map to nibbles as follows: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. The first nibble of each pair is the low half of the byte.
- R5: The symbol 01101 ends the packet and triggers the CRC verdict.
- R6: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones). It runs over every received byte, including the four check bytes, which are sent complemented with the LSB byte first. The packet passes only if the final register equals 0xDEBB20E3.
- R7: A passing packet delivers its payload bytes, meaning all received bytes except the last four, in arrival order. `rd_valid` is high on consecutive cycles. `rd_last`, `pkt_done` and `pkt_good` are all high together with the final byte.
- R8: A failing packet gives a single-cycle `pkt_done` with `pkt_good`=0, and `rd_valid` stays low for the whole packet.
- R9: Any 5-bit code in the data phase that is neither a data code nor 01101 aborts the packet with bad status.
- R10: A packet that ends after an odd number of data symbols, or that holds fewer than 5 bytes, is bad.
- R11: The buffer holds 32 bytes. A 32-byte packet (28 payload bytes plus 4 check bytes) passes. Completing a 33rd byte aborts the packet with bad status.
- R12: After reset, `rd_valid`, `rd_last`, `pkt_done` and `pkt_good` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sq_active | input | 1 | Line activity indication from the squelch detector |
| rx_bit | input | 1 | Recovered line bit |
| rx_bit_vld | input | 1 | Strobe marking `rx_bit` as a new bit |
| rd_data | output | 8 | Verified payload byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_last | output | 1 | Final payload byte of the packet |
| pkt_done | output | 1 | One-cycle packet verdict pulse |
| pkt_good | output | 1 | Verdict is pass (valid with `pkt_done`) |

## Verification
The in-line assertions check these properties on every cycle:
- output bytes come only from the replay state, and a bad verdict never carries a byte;
- the final byte always coincides with a good verdict;
- the byte count never exceeds the buffer depth;
- a quiet line forces the receiver out of the start and data phases by the next cycle;
- replay only ever follows a matching CRC residue.

Only the bench scenarios can show the other properties:
- that the decoded byte values and their order are right;
- that a single flipped bit, an illegal code, an odd nibble count, a short frame or a 33-byte frame each end in a bad verdict;
- that one damaged start symbol is tolerated while two are not.

// File: rtl/pd_rx_pkg.sv
package pd_rx_pkg;

   typedef enum logic [1:0] {
      ST_SEARCH = 2'd0,
      ST_SOP    = 2'd1,
      ST_DATA   = 2'd2,
      ST_DRAIN  = 2'd3
   } rx_state_t;

   localparam logic [4:0]  SYM_SYNC    = 5'b11000;
   localparam logic [4:0]  SYM_EOP     = 5'b01101;
   localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
   localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
   localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
   localparam int          CHK_BYTES   = 4;

endpackage

// File: rtl/pd_sym_decoder.sv
module pd_sym_decoder (
   input  logic [4:0] code,
   output logic       is_data,
   output logic       is_eop,
   output logic [3:0] nibble
);
   import pd_rx_pkg::*;

   always_comb begin
      is_data = 1'b1;
      nibble  = 4'h0;
      unique case (code)
         5'b11110: nibble = 4'h0;
         5'b01001: nibble = 4'h1;
         5'b10100: nibble = 4'h2;
         5'b10101: nibble = 4'h3;
         5'b01010: nibble = 4'h4;
         5'b01011: nibble = 4'h5;
         5'b01110: nibble = 4'h6;
         5'b01111: nibble = 4'h7;
         5'b10010: nibble = 4'h8;
         5'b10011: nibble = 4'h9;
         5'b10110: nibble = 4'hA;
         5'b10111: nibble = 4'hB;
         5'b11010: nibble = 4'hC;
         5'b11011: nibble = 4'hD;
         5'b11100: nibble = 4'hE;
         5'b11101: nibble = 4'hF;
         default:  is_data = 1'b0;
      endcase
   end

   assign is_eop = (code == SYM_EOP);

endmodule

// File: rtl/pd_crc32_byte.sv
module pd_crc32_byte #(
   parameter logic [31:0] POLY = 32'hEDB88320
) (
   input  logic [31:0] crc_in,
   input  logic [7:0]  din,
   output logic [31:0] crc_out
);
   logic [31:0] stage [0:8];

   assign stage[0] = crc_in ^ {24'd0, din};

   for (genvar i = 0; i < 8; i++) begin : g_bit
      assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY) : (stage[i] >> 1);
   end

   assign crc_out = stage[8];

endmodule

// File: rtl/pd_rx_buffer.sv
module pd_rx_buffer #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   localparam int ENTRIES = 1 << AW;

   logic [7:0] mem [0:ENTRIES-1];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pd_rx_deframer.sv
module pd_rx_deframer #(
   parameter int BUF_DEPTH = 32,
   parameter int SOP_SYMS  = 4,
   parameter int SOP_MIN   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sq_active,
   input  logic       rx_bit,
   input  logic       rx_bit_vld,
   output logic [7:0] rd_data,
   output logic       rd_valid,
   output logic       rd_last,
   output logic       pkt_done,
   output logic       pkt_good
);
   import pd_rx_pkg::*;

   localparam int AW = $clog2(BUF_DEPTH + 1);
   localparam int SW = $clog2(SOP_SYMS + 1);
   localparam logic [AW-1:0] MIN_BYTES = AW'(CHK_BYTES + 1);
   localparam logic [AW-1:0] FULL_CNT  = AW'(BUF_DEPTH);

   if (BUF_DEPTH < 8) begin : g_chk_depth
      $error("BUF_DEPTH must be at least 8");
   end
   if (SOP_MIN > SOP_SYMS || SOP_MIN < 1 || SOP_SYMS < 2) begin : g_chk_sop
      $error("SOP_MIN must lie in 1..SOP_SYMS and SOP_SYMS must be at least 2");
   end

   rx_state_t     state;
   logic [4:0]    win;
   logic [4:0]    sym;
   logic [2:0]    bcnt;
   logic [SW-1:0] scnt;
   logic [SW-1:0] smatch;
   logic [3:0]    lo_nib;
   logic          have_lo;
   logic [AW-1:0] wcnt;
   logic [AW-1:0] rcnt;
   logic [AW-1:0] rlen;
   logic [31:0]   crc;

   logic [4:0]    win_next;
   logic [4:0]    sym_next;
   logic          sym_done;
   logic          dec_data;
   logic          dec_eop;
   logic [3:0]    dec_nib;
   logic [7:0]    byte_next;
   logic [31:0]   crc_next;
   logic [SW-1:0] sop_votes;
   logic          wr_en;
   logic [7:0]    buf_rd;

   assign win_next  = {win[3:0], rx_bit};
   assign sym_next  = {sym[3:0], rx_bit};
   assign sym_done  = rx_bit_vld && (bcnt == 3'd4);
   assign byte_next = {dec_nib, lo_nib};
   assign sop_votes = smatch + SW'(sym_next == SYM_SYNC);
   assign wr_en     = (state == ST_DATA) && sq_active && sym_done && dec_data
                      && have_lo && (wcnt < FULL_CNT);

   pd_sym_decoder u_dec (
      .code    (sym_next),
      .is_data (dec_data),
      .is_eop  (dec_eop),
      .nibble  (dec_nib)
   );

   pd_crc32_byte #(.POLY(CRC_POLY)) u_crc (
      .crc_in  (crc),
      .din     (byte_next),
      .crc_out (crc_next)
   );

   pd_rx_buffer #(.AW(AW)) u_buf (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wcnt),
      .wr_data (byte_next),
      .rd_addr (rcnt),
      .rd_data (buf_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SEARCH;
         win      <= '0;
         sym      <= '0;
         bcnt     <= '0;
         scnt     <= '0;
         smatch   <= '0;
         lo_nib   <= '0;
         have_lo  <= 1'b0;
         wcnt     <= '0;
         rcnt     <= '0;
         rlen     <= '0;
         crc      <= CRC_INIT;
         rd_data  <= '0;
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
         pkt_done <= 1'b0;
         pkt_good <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
         pkt_done <= 1'b0;
         pkt_good <= 1'b0;
         unique case (state)
            ST_SEARCH: begin
               if (!sq_active) begin
                  win <= '0;
               end else if (rx_bit_vld) begin
                  win <= win_next;
                  if (win_next == SYM_SYNC) begin
                     state  <= ST_SOP;
                     bcnt   <= '0;
                     scnt   <= SW'(1);
                     smatch <= SW'(1);
                  end
               end
            end
            ST_SOP: begin
               if (!sq_active) begin
                  state <= ST_SEARCH;
                  win   <= '0;
               end else if (rx_bit_vld) begin
                  sym  <= sym_next;
                  bcnt <= bcnt + 3'd1;
                  if (sym_done) begin
                     bcnt <= '0;
                     if (scnt == SW'(SOP_SYMS - 1)) begin
                        if (sop_votes >= SW'(SOP_MIN)) begin
                           state   <= ST_DATA;
                           wcnt    <= '0;
                           have_lo <= 1'b0;
                           crc     <= CRC_INIT;
                        end else begin
                           state <= ST_SEARCH;
                           win   <= '0;
                        end
                     end else begin
                        scnt   <= scnt + SW'(1);
                        smatch <= sop_votes;
                     end
                  end
               end
            end
            ST_DATA: begin
               if (!sq_active) begin
                  state    <= ST_SEARCH;
                  win      <= '0;
                  pkt_done <= 1'b1;
               end else if (rx_bit_vld) begin
                  sym  <= sym_next;
                  bcnt <= bcnt + 3'd1;
                  if (sym_done) begin
                     bcnt <= '0;
                     if (dec_eop) begin
                        if (!have_lo && (wcnt >= MIN_BYTES) && (crc == CRC_RESIDUE)) begin
                           state <= ST_DRAIN;
                           rcnt  <= '0;
                           rlen  <= wcnt - AW'(CHK_BYTES);
                        end else begin
                           state    <= ST_SEARCH;
                           win      <= '0;
                           pkt_done <= 1'b1;
                        end
                     end else if (dec_data) begin
                        if (!have_lo) begin
                           lo_nib  <= dec_nib;
                           have_lo <= 1'b1;
                        end else if (wcnt == FULL_CNT) begin
                           state    <= ST_SEARCH;
                           win      <= '0;
                           pkt_done <= 1'b1;
                        end else begin
                           wcnt    <= wcnt + AW'(1);
                           crc     <= crc_next;
                           have_lo <= 1'b0;
                        end
                     end else begin
                        state    <= ST_SEARCH;
                        win      <= '0;
                        pkt_done <= 1'b1;
                     end
                  end
               end
            end
            ST_DRAIN: begin
               rd_valid <= 1'b1;
               rd_data  <= buf_rd;
               rcnt     <= rcnt + AW'(1);
               if (rcnt == rlen - AW'(1)) begin
                  rd_last  <= 1'b1;
                  pkt_done <= 1'b1;
                  pkt_good <= 1'b1;
                  state    <= ST_SEARCH;
                  win      <= '0;
               end
            end
            default: state <= ST_SEARCH;
         endcase
      end
   end

   AST_VALID_FROM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(state) == ST_DRAIN);                                   // R7
   AST_LAST_IS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> (rd_valid && pkt_done && pkt_good));                          // R7
   AST_BAD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && !pkt_good) |-> !rd_valid);                                   // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= FULL_CNT);                                                        // R11
   AST_QUIET_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      !sq_active |=> (state == ST_SEARCH || state == ST_DRAIN));                // R1
   AST_DRAIN_NEEDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_DATA && state == ST_DRAIN) |-> $past(crc) == CRC_RESIDUE); // R6

endmodule

// File: tb/pd_rx_deframer_tb_top.sv
module pd_rx_deframer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sq_active = 1'b0;
   logic       rx_bit = 1'b0;
   logic       rx_bit_vld = 1'b0;
   logic [7:0] rd_data;
   logic       rd_valid, rd_last, pkt_done, pkt_good;

   always #10 clk = ~clk;

   pd_rx_deframer dut_i (
      .clk(clk), .rst_n(rst_n), .sq_active(sq_active), .rx_bit(rx_bit),
      .rx_bit_vld(rx_bit_vld), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_last(rd_last), .pkt_done(pkt_done), .pkt_good(pkt_good)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [7:0] fb [0:63];
   logic [7:0] got [0:63];
   int got_n = 0;
   int last_idx = -1;
   int done_n = 0;
   bit done_good = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) begin
            if (got_n < 64) got[got_n] = rd_data;
            if (rd_last) last_idx = got_n;
            got_n++;
         end
         if (pkt_done) begin
            done_n++;
            done_good = pkt_good;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] enc(input logic [3:0] n);
      case (n)
         4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
         4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
         4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
         4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
      endcase
   endfunction

   // Fill fb[0..n-1] with payload and append the complemented CRC-32, LSB byte first (R6)
   task automatic build(input int n, input int seed);
      logic [31:0] c;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) begin
         fb[i] = 8'((i * 37 + seed * 11 + 5) & 255);
         c = c ^ {24'd0, fb[i]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      c = ~c;
      for (int j = 0; j < 4; j++) fb[n + j] = c[8*j +: 8];
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      rx_bit = b;
      rx_bit_vld = 1'b1;
      @(negedge clk);
      rx_bit_vld = 1'b0;
   endtask

   task automatic send_sym(input logic [4:0] s);
      for (int i = 4; i >= 0; i--) send_bit(s[i]);
   endtask

   task automatic send_frame(input int nbytes, input logic [3:0] sop_bad,
                             input bit use_extra, input logic [4:0] extra, input bit with_eop);
      for (int i = 0; i < 16; i++) send_bit(logic'((i % 2) == 0));
      for (int i = 0; i < 4; i++) send_sym(sop_bad[i] ? 5'b11001 : 5'b11000);
      for (int i = 0; i < nbytes; i++) begin
         send_sym(enc(fb[i][3:0]));
         send_sym(enc(fb[i][7:4]));
      end
      if (use_extra) send_sym(extra);
      if (with_eop) send_sym(5'b01101);
   endtask

   task automatic start_pkt();
      got_n = 0; last_idx = -1; done_n = 0; done_good = 1'b0;
      sq_active = 1'b1;
   endtask

   task automatic end_pkt();
      repeat (60) @(negedge clk);
      sq_active = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_good(input string tag, input int n);
      int mism;
      mism = 0;
      chk({tag, " done count"}, done_n, 1);
      chk({tag, " good status"}, int'(done_good), 1);
      chk({tag, " byte count"}, got_n, n);
      chk({tag, " last index"}, last_idx, n - 1);
      for (int i = 0; i < n && i < 64; i++) if (got[i] !== fb[i]) mism++;
      chk({tag, " byte mismatches"}, mism, 0);
   endtask

   task automatic expect_bad(input string tag);
      chk({tag, " done count"}, done_n, 1);
      chk({tag, " good status"}, int'(done_good), 0);
      chk({tag, " byte count"}, got_n, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset values
      chk("R12 rd_valid", int'(rd_valid), 0);
      chk("R12 pkt_done", int'(pkt_done), 0);
      chk("R12 rd_last", int'(rd_last), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R4 R5 R6 R7 R11: sweep payload length 1..28 (28 fills 32-byte buffer)
      for (int len = 1; len <= 28; len++) begin
         build(len, len);
         start_pkt();
         send_frame(len + 4, 4'b0000, 1'b0, 5'b0, 1'b1);
         end_pkt();
         expect_good($sformatf("R7 len %0d", len), len);
      end

      // R11: 33 bytes overflows
      build(29, 3);
      start_pkt();
      send_frame(33, 4'b0000, 1'b0, 5'b0, 1'b1);
      end_pkt();
      expect_bad("R11 overflow");

      // R6 R8: single bit error
      build(6, 9);
      fb[2] = fb[2] ^ 8'h08;
      start_pkt();
      send_frame(10, 4'b0000, 1'b0, 5'b0, 1'b1);
      end_pkt();
      expect_bad("R6 R8 crc error");

      // R9: illegal code 00000
      build(4, 2);
      start_pkt();
      send_frame(3, 4'b0000, 1'b1, 5'b00000, 1'b1);
      end_pkt();
      expect_bad("R9 illegal code");

      // R10: odd nibble count
      build(4, 4);
      start_pkt();
      send_frame(8, 4'b0000, 1'b1, 5'b11110, 1'b1);
      end_pkt();
      expect_bad("R10 odd nibbles");

      // R10: only check bytes, no payload
      build(0, 0);
      start_pkt();
      send_frame(4, 4'b0000, 1'b0, 5'b0, 1'b1);
      end_pkt();
      expect_bad("R10 short frame");

      // R3: one damaged start symbol tolerated
      build(5, 7);
      start_pkt();
      send_frame(9, 4'b0100, 1'b0, 5'b0, 1'b1);
      end_pkt();
      expect_good("R3 one bad sync", 5);

      // R3 R1: one damaged start symbol then quiet -> accepted, abort with bad status
      start_pkt();
      send_frame(0, 4'b1000, 1'b0, 5'b0, 1'b0);
      end_pkt();
      expect_bad("R3 R1 accepted then quiet");

      // R3 R1: two damaged start symbols -> rejected, quiet gives no verdict
      start_pkt();
      send_frame(0, 4'b1010, 1'b0, 5'b0, 1'b0);
      end_pkt();
      chk("R3 two bad sync done count", done_n, 0);

      // R1: full packet while line quiet is ignored
      build(5, 12);
      got_n = 0; last_idx = -1; done_n = 0;
      sq_active = 1'b0;
      send_frame(9, 4'b0000, 1'b0, 5'b0, 1'b1);
      repeat (60) @(negedge clk);
      chk("R1 quiet done count", done_n, 0);
      chk("R1 quiet byte count", got_n, 0);

      // R1 R7: block still works afterwards
      build(7, 21);
      start_pkt();
      send_frame(11, 4'b0000, 1'b0, 5'b0, 1'b1);
      end_pkt();
      expect_good("R1 after quiet", 7);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule